// File: doc/BRIEF.md
# Double-Buffered Serial Converter Front End

This block is the digital side of a 16-bit voltage-output converter driven over a three-wire serial link. A frame begins when the active-low select line goes low. While select stays low, data bits are shifted in on rising edges of the serial clock, most significant bit first. When select returns high, the shifted word is kept only if exactly `DATA_W` clock rises were seen. A kept word goes into a holding register. It reaches the output register, which drives the converter core, through one of two paths: a falling edge on the active-low load pin, or an automatic transfer when the load pin is already held low as the frame closes.

An active-low clear pin forces the output register to the midscale code on its falling edge. While clear stays low, every load request is ignored, including automatic ones. All pins are asynchronous to the system clock. Each pin passes through a chain of synchroniser flops, and all edge detection happens on the synchronised copies, so the whole design runs on one clock.

Top module: `dac_serial_frontend`

## Requirements
- R1: After power-on reset, `dac_code` is 0x8000. A load pulse given before any frame also yields 0x8000, because the holding register resets to midscale as well.
- R2: Bits are taken MSB first. After a 16-bit frame and a load pulse, `dac_code` equals the word sent.
- R3: Shifting in and closing a frame while load stays high leaves `dac_code` unchanged.
- R4: A frame with fewer than 16 clock rises, including zero, is discarded. A later load pulse gives the previously kept word.
- R5: A frame with more than 16 clock rises is discarded.
- R6: A falling edge on `load_n` while `clear_n` is high copies the holding register to `dac_code`.
- R7: If `load_n` is low when a valid frame closes, `dac_code` takes the new word with no further pulse.
- R8: A falling edge on `clear_n` sets `dac_code` to 0x8000.
- R9: While `clear_n` is low, `dac_code` stays at midscale whatever happens on `load_n` or the serial link. Clear does not disturb the holding register, so a load pulse after clear is released gives the last kept word.
- R10: When `clear_n` and `load_n` fall in the same cycle, clear wins and `dac_code` is 0x8000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| ser_csn | input | 1 | Serial frame select, active low |
| ser_sclk | input | 1 | Serial clock; data is taken on its rising edge |
| ser_din | input | 1 | Serial data, MSB first |
| load_n | input | 1 | Active-low transfer from holding to output register |
| clear_n | input | 1 | Active-low clear to midscale; blocks loads while low |
| dac_code | output | DATA_W | Code presented to the converter core |

## Verification
Frames of 0xA5C3, 0x0001, 0xFFFF and 0x8001 check bit order: a reversed shift would swap 0x0001 with 0x8000, and 0x8001 tells an MSB slip apart from an LSB slip. Frames of 15, 0 and 17 clock rises are each followed by a load pulse, to show that both the low and the high count limits discard the frame. Loads with `load_n` held low, clears with loads pulsed and frames sent during the clear, and clear and load falling together separate the edge-triggered path, the level-gated automatic path, and the clear's priority and blocking.

// File: rtl/dsf_pkg.sv
`timescale 1ns/1ps
package dsf_pkg;

  // Synchronised copies of the asynchronous pins.
  typedef struct packed {
    logic csn;
    logic sclk;
    logic din;
    logic load_n;
    logic clr_n;
  } pin_bus_t;

  localparam int PIN_W = $bits(pin_bus_t);

  // Idle level of each pin, used as the synchroniser reset value.
  localparam pin_bus_t PIN_IDLE = '{csn: 1'b1, sclk: 1'b0, din: 1'b0,
                                    load_n: 1'b1, clr_n: 1'b1};

  function automatic logic [63:0] midscale(input int width);
    logic [63:0] m;
    m = '0;
    m[width-1] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/dsf_sync.sv
`timescale 1ns/1ps
module dsf_sync #(
  parameter int              W       = 1,
  parameter int              STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[0] <= RST_VAL;
        else        stg[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[i] <= RST_VAL;
        else        stg[i] <= stg[i-1];
      end
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/dsf_shifter.sv
`timescale 1ns/1ps
module dsf_shifter #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csn,
  input  logic              sclk,
  input  logic              din,
  output logic [DATA_W-1:0] in_word,
  output logic              cap_pulse
);

  localparam int                CNT_W  = $clog2(DATA_W + 2);
  localparam logic [CNT_W-1:0]  CNT_EQ = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0]  CNT_MX = CNT_W'(DATA_W + 1);
  localparam logic [DATA_W-1:0] MID    = DATA_W'(dsf_pkg::midscale(DATA_W));

  logic              sclk_q, csn_q;
  logic [DATA_W-1:0] shreg;
  logic [CNT_W-1:0]  nbits;

  wire sclk_rise = sclk & ~sclk_q;
  wire csn_rise  = csn & ~csn_q;
  wire frame_ok  = csn_rise && (nbits == CNT_EQ);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      csn_q  <= 1'b1;
    end else begin
      sclk_q <= sclk;
      csn_q  <= csn;
    end
  end

  // Shift and count rises while selected; saturate above DATA_W so an
  // overlong frame never wraps back into a valid count.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
      nbits <= '0;
    end else if (csn) begin
      nbits <= '0;
    end else if (sclk_rise) begin
      shreg <= {shreg[DATA_W-2:0], din};
      if (nbits != CNT_MX) nbits <= nbits + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_word   <= MID;
      cap_pulse <= 1'b0;
    end else begin
      cap_pulse <= frame_ok;
      if (frame_ok) in_word <= shreg;
    end
  end

endmodule

// File: rtl/dsf_dac_reg.sv
`timescale 1ns/1ps
module dsf_dac_reg #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_n,
  input  logic              clr_n,
  input  logic              cap_pulse,
  input  logic [DATA_W-1:0] in_word,
  output logic [DATA_W-1:0] dac_code
);

  localparam logic [DATA_W-1:0] MID = DATA_W'(dsf_pkg::midscale(DATA_W));

  logic load_q, clr_q;

  wire clr_fall  = ~clr_n & clr_q;
  wire load_fall = ~load_n & load_q;
  wire auto_ld   = cap_pulse & ~load_n;
  wire take      = clr_n & (load_fall | auto_ld);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q <= 1'b1;
      clr_q  <= 1'b1;
    end else begin
      load_q <= load_n;
      clr_q  <= clr_n;
    end
  end

  // Clear edge has priority; any transfer is gated off while clear is low.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        dac_code <= MID;
    else if (clr_fall) dac_code <= MID;
    else if (take)     dac_code <= in_word;
  end

endmodule

// File: rtl/dac_serial_frontend.sv
`timescale 1ns/1ps
module dac_serial_frontend #(
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_csn,
  input  logic              ser_sclk,
  input  logic              ser_din,
  input  logic              load_n,
  input  logic              clear_n,
  output logic [DATA_W-1:0] dac_code
);

  import dsf_pkg::*;

  pin_bus_t          pins_raw, pins_s;
  logic              s_csn, s_sclk, s_din, s_load_n, s_clr_n;
  logic [DATA_W-1:0] in_word;
  logic              cap_pulse;

  assign pins_raw = '{csn: ser_csn, sclk: ser_sclk, din: ser_din,
                      load_n: load_n, clr_n: clear_n};

  dsf_sync #(
    .W       (PIN_W),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (PIN_IDLE)
  ) i_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pins_raw),
    .q     (pins_s)
  );

  assign s_csn    = pins_s.csn;
  assign s_sclk   = pins_s.sclk;
  assign s_din    = pins_s.din;
  assign s_load_n = pins_s.load_n;
  assign s_clr_n  = pins_s.clr_n;

  dsf_shifter #(.DATA_W(DATA_W)) i_shifter (
    .clk       (clk),
    .rst_n     (rst_n),
    .csn       (s_csn),
    .sclk      (s_sclk),
    .din       (s_din),
    .in_word   (in_word),
    .cap_pulse (cap_pulse)
  );

  dsf_dac_reg #(.DATA_W(DATA_W)) i_dac_reg (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_n    (s_load_n),
    .clr_n     (s_clr_n),
    .cap_pulse (cap_pulse),
    .in_word   (in_word),
    .dac_code  (dac_code)
  );

endmodule

// File: rtl/dsf_chk.sv
`timescale 1ns/1ps
module dsf_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              s_csn,
  input logic              s_load_n,
  input logic              s_clr_n,
  input logic              cap_pulse,
  input logic [DATA_W-1:0] in_word,
  input logic [DATA_W-1:0] dac_code
);

  localparam logic [DATA_W-1:0] MID = DATA_W'(dsf_pkg::midscale(DATA_W));

  // R3
  dac_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_code != $past(dac_code)) |-> (!$past(s_load_n) || !$past(s_clr_n)));

  // R4
  in_word_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_word != $past(in_word)) |-> ($past(s_csn) && !$past(s_csn, 2)));

  // R6
  load_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(s_load_n) && s_clr_n) |=> (dac_code == $past(in_word)));

  // R7
  auto_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_pulse && !s_load_n && s_clr_n) |=> (dac_code == $past(in_word)));

  // R8
  clear_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(s_clr_n) |=> (dac_code == MID));

  // R9
  clear_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!s_clr_n && !$fell(s_clr_n)) |=> $stable(dac_code));

endmodule

bind dac_serial_frontend dsf_chk #(.DATA_W(DATA_W)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .s_csn     (s_csn),
  .s_load_n  (s_load_n),
  .s_clr_n   (s_clr_n),
  .cap_pulse (cap_pulse),
  .in_word   (in_word),
  .dac_code  (dac_code)
);

// File: tb/test_dac_serial_frontend.sv
`timescale 1ns/1ps
module test_dac_serial_frontend;

  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ser_csn = 1'b1, ser_sclk = 1'b0, ser_din = 1'b0;
  logic          load_n = 1'b1, clear_n = 1'b1;
  logic [DW-1:0] dac_code;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  dac_serial_frontend #(.DATA_W(DW)) i_dac_serial_frontend (
    .clk      (clk),
    .rst_n    (rst_n),
    .ser_csn  (ser_csn),
    .ser_sclk (ser_sclk),
    .ser_din  (ser_din),
    .load_n   (load_n),
    .clear_n  (clear_n),
    .dac_code (dac_code)
  );

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string tag, input logic [DW-1:0] got,
                       input logic [DW-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: dac_code=%h expected %h", tag, got, exp);
    end
  endtask

  // Sends the top nbits of word MSB first, padding with zeros past DW.
  task automatic send_frame(input logic [DW-1:0] word, input int nbits);
    ser_csn = 1'b0;
    cyc(4);
    for (int i = 0; i < nbits; i++) begin
      ser_din = (i < DW) ? word[DW-1-i] : 1'b0;
      cyc(4);
      ser_sclk = 1'b1;
      cyc(4);
      ser_sclk = 1'b0;
    end
    cyc(4);
    ser_csn = 1'b1;
    cyc(10);
  endtask

  task automatic pulse_load();
    load_n = 1'b0;
    cyc(6);
    load_n = 1'b1;
    cyc(6);
  endtask

  task automatic t_reset();
    check("R1 reset", dac_code, 16'h8000);
    pulse_load();
    check("R1 holding reg midscale", dac_code, 16'h8000);
  endtask

  task automatic t_basic();
    logic [DW-1:0] pats [4] = '{16'hA5C3, 16'h0001, 16'hFFFF, 16'h8001};
    logic [DW-1:0] prev;
    for (int k = 0; k < 4; k++) begin
      prev = dac_code;
      send_frame(pats[k], DW);
      check("R3 frame without load", dac_code, prev);
      pulse_load();
      check("R2 R6 load after frame", dac_code, pats[k]);
    end
  endtask

  task automatic t_bad_count();
    send_frame(16'h1234, 15);
    pulse_load();
    check("R4 short frame", dac_code, 16'h8001);
    send_frame(16'h5555, 0);
    pulse_load();
    check("R4 empty frame", dac_code, 16'h8001);
    send_frame(16'h4321, 17);
    pulse_load();
    check("R5 long frame", dac_code, 16'h8001);
  endtask

  task automatic t_auto();
    load_n = 1'b0;
    cyc(6);
    send_frame(16'h3C3C, DW);
    check("R7 auto update", dac_code, 16'h3C3C);
    send_frame(16'h0F0F, DW);
    check("R7 second auto update", dac_code, 16'h0F0F);
    send_frame(16'h7777, 15);
    check("R4 short frame no auto update", dac_code, 16'h0F0F);
    load_n = 1'b1;
    cyc(6);
  endtask

  task automatic t_clear();
    send_frame(16'h6A6A, DW);
    clear_n = 1'b0;
    cyc(6);
    check("R8 clear to midscale", dac_code, 16'h8000);
    pulse_load();
    check("R9 load ignored in clear", dac_code, 16'h8000);
    load_n = 1'b0;
    send_frame(16'h1111, DW);
    check("R9 auto load ignored in clear", dac_code, 16'h8000);
    load_n = 1'b1;
    cyc(6);
    clear_n = 1'b1;
    cyc(6);
    check("R9 release keeps midscale", dac_code, 16'h8000);
    pulse_load();
    check("R9 holding reg kept", dac_code, 16'h1111);
  endtask

  task automatic t_prio();
    check("R10 precondition", dac_code, 16'h1111);
    clear_n = 1'b0;
    load_n  = 1'b0;
    cyc(6);
    check("R10 clear wins", dac_code, 16'h8000);
    load_n = 1'b1;
    cyc(4);
    clear_n = 1'b1;
    cyc(6);
    check("R10 stays midscale", dac_code, 16'h8000);
  endtask

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(5);
    t_reset();
    t_basic();
    t_bad_count();
    t_auto();
    t_clear();
    t_prio();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: run incomplete, got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule